// File: doc/BRIEF.md
# Interrupt Entry Register Push Sequencer

This block performs the register-save step of an interrupt acknowledge. When the surrounding controller pulses `start_i`, the block captures the current stack pointer, the 8-bit program bank, the 16-bit program counter and the 16-bit status word. It then stores them on the stack below the captured stack pointer through a simple 16-bit memory write port. That port has a request, a byte address, write data, per-byte enables and a ready handshake.

The parity of the captured stack pointer chooses the transfer pattern. An even stack pointer needs three writes: a byte write for the bank, then two aligned word writes. An odd stack pointer needs five single-byte writes. In both cases the bytes end up in the same places. When the last write is accepted, the block pulses `done_o` and presents the decremented stack pointer on `sp_o`.

Top module: `intr_push_seq`

## Requirements
- R1: The stack pointer and the register values are captured in the cycle `start_i` is sampled while idle. Later changes on `sp_i`, `bank_i`, `pc_i` and `ps_i` have no effect on the transfers. A `start_i` sampled while `busy_o` is high is ignored.
- R2: When a sequence completes, the bytes written are: bank at S, PC[15:8] at S-1, PC[7:0] at S-2, PS[15:8] at S-3 and PS[7:0] at S-4. S is the captured stack pointer. The bank byte is always written first.
- R3: For even S there are exactly three transfers, in this order:
  - a byte write of the bank at S;
  - a word write at S-2 with data = PC and `mem_be_o` = 2'b11;
  - a word write at S-4 with data = PS and `mem_be_o` = 2'b11.
- R4: For odd S there are exactly five byte transfers, in this order: bank at S, PC high at S-1, PC low at S-2, PS high at S-3, PS low at S-4.
- R5: A byte write to an even address uses `mem_be_o` = 2'b01 with the byte on `mem_wdata_o[7:0]`. A byte write to an odd address uses 2'b10 with the byte on `mem_wdata_o[15:8]`. The unused lane is driven to zero. A word write is only made to an even address.
- R6: While `mem_req_o` is high and `mem_ready_i` is low, the address, data and enables stay unchanged. The sequencer advances only on a cycle where both are high.
- R7: `done_o` is high for exactly one cycle, the cycle after the last transfer is accepted. In that cycle `sp_o` equals S-5 and `mem_req_o` is low.
- R8: All address arithmetic wraps modulo 2^16.
- R9: After reset, `busy_o`, `mem_req_o` and `done_o` are low. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle, and `mem_req_o` is high only while transfers are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a save sequence (taken only while idle) |
| sp_i | input | 16 | Stack pointer at acknowledge |
| bank_i | input | 8 | Program bank to save |
| pc_i | input | 16 | Program counter to save |
| ps_i | input | 16 | Status word to save |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | 16 | Byte address of the write |
| mem_wdata_o | output | 16 | Write data, low lane = even byte |
| mem_be_o | output | 2 | Byte enables, bit 0 = even byte lane |
| mem_ready_i | input | 1 | Write accepted when high with request |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Updated stack pointer, valid with done_o |

## Verification
The assertions check several properties on every cycle:
- request stability during stalls;
- the lane and alignment rules for each write;
- the single-cycle completion pulse, with the request low at that point;
- the transfer count for each parity;
- the returned stack pointer, measured against the value the checker recorded at start.

The exact address and data of each transfer, and the final byte layout, are shown only by the bench's scenarios. Those scenarios cover both parities, wrap-around near zero and 0xFFFF, random stalls, input changes during a sequence, and starts issued while busy.

// File: rtl/intr_push_pkg.sv
package intr_push_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } push_st_e;
endpackage

// File: rtl/intr_push_ctrl.sv
module intr_push_ctrl
  import intr_push_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              last_i,
  output push_st_e          state_o,
  output logic [STEP_W-1:0] step_o,
  output logic              cap_en_o
);
  push_st_e          state_q;
  logic [STEP_W-1:0] step_q;

  assign cap_en_o = (state_q == ST_IDLE) && start_i;
  assign state_o  = state_q;
  assign step_o   = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_XFER;
          step_q  <= '0;
        end
        ST_XFER: if (ack_i) begin
          if (last_i) state_q <= ST_DONE;
          else        step_q  <= step_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_push_plan.sv
module intr_push_plan
  import intr_push_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int BANK_W = 8,
  parameter int WORD_W = 16,
  parameter int STEP_W = 3
) (
  input  logic [SP_W-1:0]   sp_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] ps_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [SP_W-1:0]   addr_o,
  output logic              is_word_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam logic [STEP_W-1:0] LAST_EVEN = STEP_W'(2);
  localparam logic [STEP_W-1:0] LAST_ODD  = STEP_W'(4);

  logic            odd;
  logic [SP_W-1:0] offset;

  assign odd = sp_i[0];

  // even: offsets 0,2,4 ; odd: offsets 0..4
  always_comb begin
    offset = odd ? SP_W'(step_i) : SP_W'({step_i, 1'b0});
  end

  assign addr_o    = sp_i - offset;
  assign last_o    = odd ? (step_i == LAST_ODD) : (step_i == LAST_EVEN);
  assign is_word_o = !odd && (step_i != '0);
  assign word_o    = (step_i == STEP_W'(1)) ? pc_i : ps_i;

  always_comb begin
    unique case (step_i)
      STEP_W'(1): byte_o = pc_i[15:8];
      STEP_W'(2): byte_o = pc_i[7:0];
      STEP_W'(3): byte_o = ps_i[15:8];
      STEP_W'(4): byte_o = ps_i[7:0];
      default:    byte_o = BYTE_W'(bank_i);
    endcase
  end
endmodule

// File: rtl/intr_push_lanes.sv
module intr_push_lanes
  import intr_push_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = WORD_W / BYTE_W,
  parameter int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              is_word_i,
  input  logic [SEL_W-1:0]  lane_sel_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit;
    assign hit = is_word_i || (lane_sel_i == SEL_W'(l));
    assign be_o[l] = hit;
    assign wdata_o[l*BYTE_W +: BYTE_W] =
      is_word_i ? word_i[l*BYTE_W +: BYTE_W] : (hit ? byte_i : '0);
  end
endmodule

// File: rtl/intr_push_seq.sv
module intr_push_seq
  import intr_push_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int BANK_W = 8,
  parameter int WORD_W = 16,
  parameter int STEP_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [SP_W-1:0]          sp_i,
  input  logic [BANK_W-1:0]        bank_i,
  input  logic [WORD_W-1:0]        pc_i,
  input  logic [WORD_W-1:0]        ps_i,
  output logic                     busy_o,
  output logic                     mem_req_o,
  output logic [SP_W-1:0]          mem_addr_o,
  output logic [WORD_W-1:0]        mem_wdata_o,
  output logic [WORD_W/BYTE_W-1:0] mem_be_o,
  input  logic                     mem_ready_i,
  output logic                     done_o,
  output logic [SP_W-1:0]          sp_o
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [SP_W-1:0] FRAME_BYTES = SP_W'(5);

  logic [SP_W-1:0]   sp_q;
  logic [BANK_W-1:0] bank_q;
  logic [WORD_W-1:0] pc_q, ps_q;

  push_st_e          state;
  logic [STEP_W-1:0] step;
  logic              cap_en, ack, last;
  logic [SP_W-1:0]   addr;
  logic              is_word;
  logic [BYTE_W-1:0] byte_val;
  logic [WORD_W-1:0] word_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= '0;
      bank_q <= '0;
      pc_q   <= '0;
      ps_q   <= '0;
    end else if (cap_en) begin
      sp_q   <= sp_i;
      bank_q <= bank_i;
      pc_q   <= pc_i;
      ps_q   <= ps_i;
    end
  end

  assign ack = mem_req_o && mem_ready_i;

  intr_push_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ack_i   (ack),
    .last_i  (last),
    .state_o (state),
    .step_o  (step),
    .cap_en_o(cap_en)
  );

  intr_push_plan #(
    .SP_W(SP_W), .BANK_W(BANK_W), .WORD_W(WORD_W), .STEP_W(STEP_W)
  ) u_plan (
    .sp_i     (sp_q),
    .bank_i   (bank_q),
    .pc_i     (pc_q),
    .ps_i     (ps_q),
    .step_i   (step),
    .addr_o   (addr),
    .is_word_o(is_word),
    .byte_o   (byte_val),
    .word_o   (word_val),
    .last_o   (last)
  );

  intr_push_lanes #(.WORD_W(WORD_W), .LANES(LANES), .SEL_W(SEL_W)) u_lanes (
    .is_word_i (is_word),
    .lane_sel_i(addr[SEL_W-1:0]),
    .byte_i    (byte_val),
    .word_i    (word_val),
    .wdata_o   (mem_wdata_o),
    .be_o      (mem_be_o)
  );

  assign busy_o     = (state != ST_IDLE);
  assign mem_req_o  = (state == ST_XFER);
  assign mem_addr_o = addr;
  assign done_o     = (state == ST_DONE);
  assign sp_o       = sp_q - FRAME_BYTES;
endmodule

// File: rtl/intr_push_seq_chk.sv
module intr_push_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] sp_i,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic [15:0] mem_addr_o,
  input logic [15:0] mem_wdata_o,
  input logic [1:0]  mem_be_o,
  input logic        mem_ready_i,
  input logic        done_o,
  input logic [15:0] sp_o
);
  logic [15:0] sp_seen;
  logic [2:0]  acc_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_seen <= '0;
      acc_cnt <= '0;
    end else begin
      if (start_i && !busy_o) begin
        sp_seen <= sp_i;
        acc_cnt <= '0;
      end else if (mem_req_o && mem_ready_i) begin
        acc_cnt <= acc_cnt + 3'd1;
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_be_o));

  // R5
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $countones(mem_be_o) == 1 |->
      mem_be_o == (mem_addr_o[0] ? 2'b10 : 2'b01));

  // R5
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_be_o == 2'b11 |-> !mem_addr_o[0]);

  // R5
  lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_be_o == 2'b01 |-> mem_wdata_o[15:8] == 8'h00);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o && busy_o);

  // R7 R8
  new_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sp_o == sp_seen - 16'd5);

  // R3 R4
  xfer_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> acc_cnt == (sp_seen[0] ? 3'd5 : 3'd3));

  // R9
  req_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind intr_push_seq intr_push_seq_chk u_chk (.*);

// File: tb/sim_intr_push_seq.sv
module sim_intr_push_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] sp_i = '0;
  logic [7:0]  bank_i = '0;
  logic [15:0] pc_i = '0, ps_i = '0;
  logic        busy_o, mem_req_o, mem_ready_i, done_o;
  logic [15:0] mem_addr_o, mem_wdata_o, sp_o;
  logic [1:0]  mem_be_o;

  int n_chk = 0, n_bad = 0;

  logic [15:0] ex_addr [5];
  logic [15:0] ex_data [5];
  logic [1:0]  ex_be   [5];
  int          ex_n;

  always #2 clk_i = ~clk_i;

  intr_push_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_byte(input logic [15:0] a, input logic [7:0] b);
    return a[0] ? {b, 8'h00} : {8'h00, b};
  endfunction

  task automatic plan(input logic [15:0] s, input logic [7:0] bk,
                      input logic [15:0] pc, input logic [15:0] ps);
    logic [7:0] seq [5];
    seq[0] = bk; seq[1] = pc[15:8]; seq[2] = pc[7:0];
    seq[3] = ps[15:8]; seq[4] = ps[7:0];
    if (!s[0]) begin
      ex_n = 3;
      ex_addr[0] = s;         ex_data[0] = {8'h00, bk}; ex_be[0] = 2'b01;
      ex_addr[1] = s - 16'd2; ex_data[1] = pc;          ex_be[1] = 2'b11;
      ex_addr[2] = s - 16'd4; ex_data[2] = ps;          ex_be[2] = 2'b11;
    end else begin
      ex_n = 5;
      for (int k = 0; k < 5; k++) begin
        ex_addr[k] = s - 16'(k);
        ex_data[k] = lane_byte(ex_addr[k], seq[k]);
        ex_be[k]   = ex_addr[k][0] ? 2'b10 : 2'b01;
      end
    end
  endtask

  // stall: 0 none, 1 random, 2 heavy
  task automatic run_push(input logic [15:0] s, input logic [7:0] bk,
                          input logic [15:0] pc, input logic [15:0] ps,
                          input int stall, input bit poke);
    logic [7:0] got [logic [15:0]];
    int k = 0, guard = 0;
    bit fin = 0;
    string rq;
    plan(s, bk, pc, ps);
    @(negedge clk_i);
    sp_i = s; bank_i = bk; pc_i = pc; ps_i = ps; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R1: scramble inputs, optionally retry start while busy
    sp_i = ~s; bank_i = ~bk; pc_i = ~pc; ps_i = ~ps;
    while (!fin) begin
      chk(busy_o === 1'b1, "R9 busy", busy_o, 1);
      start_i = poke ? 1'($urandom_range(1)) : 1'b0;
      if (done_o === 1'b1) begin
        chk(k == ex_n, "R3 R4 count", k, ex_n);
        chk(sp_o === s - 16'd5, "R7 R8 sp_o", sp_o, s - 16'd5);
        chk(mem_req_o === 1'b0, "R7 req low", mem_req_o, 0);
        fin = 1;
      end else begin
        rq = s[0] ? "R4 R5" : "R3 R5";
        chk(mem_req_o === 1'b1, "R6 req", mem_req_o, 1);
        if (k < ex_n) begin
          chk(mem_addr_o === ex_addr[k], {rq, " R1 R8 addr"}, mem_addr_o, ex_addr[k]);
          chk(mem_wdata_o === ex_data[k], {rq, " R1 data"}, mem_wdata_o, ex_data[k]);
          chk(mem_be_o === ex_be[k], {rq, " be"}, mem_be_o, ex_be[k]);
        end else chk(0, "R3 R4 extra xfer", k, ex_n);
        case (stall)
          0: mem_ready_i = 1'b1;
          1: mem_ready_i = 1'($urandom_range(1));
          default: mem_ready_i = ($urandom_range(3) == 0);
        endcase
        if (mem_ready_i) begin
          if (mem_be_o[0]) got[mem_addr_o & 16'hFFFE] = mem_wdata_o[7:0];
          if (mem_be_o[1]) got[mem_addr_o | 16'h0001] = mem_wdata_o[15:8];
          k++;
        end
      end
      @(negedge clk_i);
      mem_ready_i = 1'b0;
      if (++guard > 200) begin
        chk(0, "R7 watchdog", guard, 200);
        fin = 1;
      end
    end
    start_i = 1'b0;
    // R2: final byte layout
    chk(got.exists(s) && got[s] === bk, "R2 bank", got.exists(s) ? got[s] : 8'hxx, bk);
    chk(got.exists(s - 16'd1) && got[s - 16'd1] === pc[15:8], "R2 pc_hi", 0, pc[15:8]);
    chk(got.exists(s - 16'd2) && got[s - 16'd2] === pc[7:0], "R2 pc_lo", 0, pc[7:0]);
    chk(got.exists(s - 16'd3) && got[s - 16'd3] === ps[15:8], "R2 ps_hi", 0, ps[15:8]);
    chk(got.exists(s - 16'd4) && got[s - 16'd4] === ps[7:0], "R2 ps_lo", 0, ps[7:0]);
    chk(done_o === 1'b0, "R7 one cycle", done_o, 0);
    chk(busy_o === 1'b0, "R9 idle", busy_o, 0);
  endtask

  initial begin
    mem_ready_i = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    chk(busy_o === 1'b0, "R9 reset busy", busy_o, 0);
    chk(mem_req_o === 1'b0, "R9 reset req", mem_req_o, 0);
    chk(done_o === 1'b0, "R9 reset done", done_o, 0);
    // R1: no start, nothing happens
    repeat (3) @(negedge clk_i);
    chk(mem_req_o === 1'b0, "R1 no start", mem_req_o, 0);

    run_push(16'h1234, 8'hA5, 16'hBEEF, 16'h5A3C, 0, 0);
    run_push(16'h1235, 8'h3C, 16'hCAFE, 16'h0F1E, 0, 0);
    run_push(16'h0000, 8'h11, 16'h2233, 16'h4455, 1, 0);  // R8 wrap even
    run_push(16'h0001, 8'h66, 16'h7788, 16'h99AA, 1, 0);  // R8 wrap odd
    run_push(16'h0003, 8'hFF, 16'h0000, 16'hFFFF, 2, 1);
    run_push(16'hFFFF, 8'h01, 16'h8001, 16'h7FFE, 2, 1);
    run_push(16'h0004, 8'h5A, 16'h1357, 16'h2468, 2, 1);  // R6 heavy stall

    for (int i = 0; i < 60; i++)
      run_push(16'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
               int'($urandom_range(2)), 1'($urandom_range(1)));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL R7 global watchdog act=%h exp=%h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule